// File: doc/BRIEF.md
# Configuration Power-Up and Clear Sequencer

This block runs the front end of configuration for a programmable device. After the core supply is declared valid (reset released), it sits out a power-on interval. It then clears the configuration memory, which is modelled here as a busy interval of fixed length. While it does this it pulls an open-drain, active-low init line low. Once clearing ends it lets go of the line. It does not enter the data-load phase until it actually senses the line high, so an outside agent can stretch the wait by holding the wired-AND line low.

At the cycle where the sequencer sees the line high, it captures the mode pins and enters the load phase. In clock-master mode, after a programmable delay, it starts a free-running configuration clock output. An active-low program request that stays low for a minimum number of cycles sends the block from any state back to a held-clear state. When the request is released, clearing starts again. Shorter glitches are ignored.

States: POR_WAIT (power-on interval), CLEAR (memory clear), INIT_WAIT (line released, waiting to sense it high), LOAD (data-load phase), IDLE (program request held). Transitions:
- POR_WAIT→CLEAR when the power-on count expires.
- CLEAR→INIT_WAIT when the clear count expires.
- INIT_WAIT→LOAD on a sensed high line.
- any state→IDLE on an accepted program request.
- IDLE→CLEAR on the first cycle the request is high.

Top module: `cfg_pwrup_seq`

## Requirements
- R1: While rst_n is low, init_drive_low is 1, load_active is 0, cfg_clk_out is 0 and mode_q is 0.
- R2: After rst_n is released, init_drive_low stays 1 for exactly POR_CYCLES + CLEAR_CYCLES rising clock edges and is 0 after the last of them.
- R3: A program request is accepted in any state once prog_n has been sampled low on PROG_MIN_CYCLES consecutive edges. init_drive_low is 1 from that edge on for as long as prog_n stays low.
- R4: A low pulse on prog_n sampled on fewer than PROG_MIN_CYCLES edges is ignored: a block in the load phase keeps load_active at 1 and init_drive_low at 0.
- R5: After an accepted request, clearing starts at the first edge that samples prog_n high. init_drive_low returns to 0 after exactly CLEAR_CYCLES + 1 edges counted from that edge.
- R6: After clearing, load_active stays 0 for as long as init_sense is low. It becomes 1 at the first edge that samples init_sense high, and init_drive_low is 0 throughout the load phase.
- R7: mode_q takes the value of mode_pins sampled on the edge that enters the load phase and holds it for as long as the load phase lasts.
- R8: With mode_q[0] = 0 (clock master), cfg_clk_out first rises exactly CCLK_DELAY_CYCLES + CCLK_HALF_CYCLES edges after the edge that enters the load phase. It then toggles every CCLK_HALF_CYCLES edges.
- R9: With mode_q[0] = 1 (clock slave), cfg_clk_out stays 0 during the load phase.
- R10: cfg_clk_out is 0 whenever load_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; released when the core supply is valid |
| prog_n | input | 1 | Active-low program request |
| init_sense | input | 1 | Resolved level of the wired-AND init line |
| mode_pins | input | MODE_W | Configuration mode pins |
| init_drive_low | output | 1 | Enable that pulls the init line low |
| cfg_clk_out | output | 1 | Configuration clock output (master mode) |
| mode_q | output | MODE_W | Mode value captured on entry to the load phase |
| load_active | output | 1 | High while in the data-load phase |

## Verification
The bench builds the block with POR_CYCLES = 20, CLEAR_CYCLES = 12, PROG_MIN_CYCLES = 5, CCLK_DELAY_CYCLES = 3 and CCLK_HALF_CYCLES = 2. These short intervals let one run measure the full power-on and clear durations exactly and repeat many reprogram cycles. Every rejected pulse width from 1 to 4 cycles can be tried, along with accepted widths just at and above the threshold. The clock start and half period are counted edge by edge. Random external holds of up to five cycles on the init line, together with random mode values, exercise the stall, both clock modes and mode capture.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_POR_WAIT,
        ST_CLEAR,
        ST_INIT_WAIT,
        ST_LOAD,
        ST_IDLE
    } seq_state_e;

endpackage

// File: rtl/cfgseq_prog_filter.sv
// Minimum-width filter for the active-low program request.
module cfgseq_prog_filter #(
    parameter int MIN_LOW = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    output logic req_active
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (prog_n) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != LAST) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // Active from the MIN_LOW-th consecutive low sample onwards
    assign req_active = !prog_n && (low_cnt_q == LAST);

endmodule

// File: rtl/cfgseq_phase_timer.sv
// Saturating cycle counter restarted on every state change.
module cfgseq_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] elapsed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (elapsed != '1) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/cfgseq_cclk_gen.sv
// Delayed-start configuration clock generator.
module cfgseq_cclk_gen #(
    parameter int DELAY = 50,
    parameter int HALF  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic cclk_o
);
    localparam int DW = $clog2(DELAY + 2);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DW-1:0] dcnt_q;
    logic [HW-1:0] hcnt_q;
    logic          cclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
            hcnt_q <= '0;
            cclk_q <= 1'b0;
        end else if (!en) begin
            dcnt_q <= '0;
            hcnt_q <= '0;
            cclk_q <= 1'b0;
        end else if (dcnt_q != DW'(DELAY)) begin
            dcnt_q <= dcnt_q + 1'b1;
        end else if (hcnt_q == HW'(HALF - 1)) begin
            hcnt_q <= '0;
            cclk_q <= ~cclk_q;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    // Gate so the output drops in the same cycle the enable does
    assign cclk_o = cclk_q & en;

endmodule

// File: rtl/cfg_pwrup_seq.sv
module cfg_pwrup_seq
    import cfgseq_pkg::*;
#(
    parameter int POR_CYCLES        = 200000,
    parameter int CLEAR_CYCLES      = 1024,
    parameter int PROG_MIN_CYCLES   = 30,
    parameter int CCLK_DELAY_CYCLES = 50,
    parameter int CCLK_HALF_CYCLES  = 4,
    parameter int MODE_W            = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n,
    input  logic              init_sense,
    input  logic [MODE_W-1:0] mode_pins,
    output logic              init_drive_low,
    output logic              cfg_clk_out,
    output logic [MODE_W-1:0] mode_q,
    output logic              load_active
);
    localparam int TMAX = (POR_CYCLES > CLEAR_CYCLES) ? POR_CYCLES : CLEAR_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] POR_LAST   = TW'(POR_CYCLES - 1);
    localparam logic [TW-1:0] CLEAR_LAST = TW'(CLEAR_CYCLES - 1);

    seq_state_e    state_q, state_d;
    logic [TW-1:0] elapsed;
    logic          req_active;
    logic          cclk_en;

    cfgseq_prog_filter #(.MIN_LOW(PROG_MIN_CYCLES)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_n     (prog_n),
        .req_active (req_active)
    );

    cfgseq_phase_timer #(.CNT_W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .elapsed (elapsed)
    );

    cfgseq_cclk_gen #(.DELAY(CCLK_DELAY_CYCLES), .HALF(CCLK_HALF_CYCLES)) u_cclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cclk_en),
        .cclk_o (cfg_clk_out)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR_WAIT:  if (elapsed == POR_LAST)   state_d = ST_CLEAR;
            ST_CLEAR:     if (elapsed == CLEAR_LAST) state_d = ST_INIT_WAIT;
            ST_INIT_WAIT: if (init_sense)            state_d = ST_LOAD;
            ST_LOAD:      state_d = ST_LOAD;
            ST_IDLE:      if (!req_active)           state_d = ST_CLEAR;
            default:      state_d = ST_POR_WAIT;
        endcase
        if (req_active) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POR_WAIT;
        else        state_q <= state_d;
    end

    // Mode capture at the sensed release of the init line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (state_q == ST_INIT_WAIT && init_sense) begin
            mode_q <= mode_pins;
        end
    end

    // Outputs
    always_comb begin
        init_drive_low = 1'b0;
        load_active    = 1'b0;
        unique case (state_q)
            ST_POR_WAIT, ST_CLEAR, ST_IDLE: init_drive_low = 1'b1;
            ST_LOAD:                        load_active    = 1'b1;
            default:                        ;
        endcase
        cclk_en = load_active && !mode_q[0];
    end

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker #(
    parameter int CLEAR_CYCLES    = 1024,
    parameter int PROG_MIN_CYCLES = 30,
    parameter int MODE_W          = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_n,
    input logic              init_sense,
    input logic              init_drive_low,
    input logic              cfg_clk_out,
    input logic [MODE_W-1:0] mode_q,
    input logic              load_active
);
    localparam int SAT = 1 << 30;

    int drv_run;
    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_run <= 0;
            low_run <= 0;
        end else begin
            drv_run <= !init_drive_low ? 0 : (drv_run < SAT ? drv_run + 1 : drv_run);
            low_run <= prog_n ? 0 : (low_run < SAT ? low_run + 1 : low_run);
        end
    end

    AST_CLEAR_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_drive_low && $past(init_drive_low)) |-> (drv_run >= CLEAR_CYCLES)); // R5

    AST_SHORT_PULSE_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_active && $past(load_active)) |-> (low_run >= PROG_MIN_CYCLES)); // R4

    AST_LOAD_AFTER_INIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && !$past(load_active)) |-> $past(init_sense)); // R6

    AST_RELEASED_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_active |-> !init_drive_low); // R6

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && $past(load_active)) |-> $stable(mode_q)); // R7

    AST_CCLK_ONLY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_active |-> !cfg_clk_out); // R10

endmodule

bind cfg_pwrup_seq cfgseq_checker #(
    .CLEAR_CYCLES    (CLEAR_CYCLES),
    .PROG_MIN_CYCLES (PROG_MIN_CYCLES),
    .MODE_W          (MODE_W)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .prog_n         (prog_n),
    .init_sense     (init_sense),
    .init_drive_low (init_drive_low),
    .cfg_clk_out    (cfg_clk_out),
    .mode_q         (mode_q),
    .load_active    (load_active)
);

// File: tb/cfg_pwrup_seq_bench.sv
module cfg_pwrup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int POR  = 20;
    localparam int CLR  = 12;
    localparam int PMIN = 5;
    localparam int DLY  = 3;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_n = 1'b1;
    logic       ext_hold = 1'b0;
    logic [2:0] mode_pins = 3'b000;
    logic       init_sense;
    logic       init_drive_low;
    logic       cfg_clk_out;
    logic [2:0] mode_q;
    logic       load_active;
    bit         done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // Wired-AND init line
    assign init_sense = !(init_drive_low || ext_hold);

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_pwrup_seq #(
        .POR_CYCLES        (POR),
        .CLEAR_CYCLES      (CLR),
        .PROG_MIN_CYCLES   (PMIN),
        .CCLK_DELAY_CYCLES (DLY),
        .CCLK_HALF_CYCLES  (HALF),
        .MODE_W            (3)
    ) u_cfg_pwrup_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_n         (prog_n),
        .init_sense     (init_sense),
        .mode_pins      (mode_pins),
        .init_drive_low (init_drive_low),
        .cfg_clk_out    (cfg_clk_out),
        .mode_q         (mode_q),
        .load_active    (load_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Edges from load entry to the first clock rise; -1 for slave mode
    function automatic int exp_cclk_rise(input logic [2:0] m);
        return m[0] ? -1 : DLY + HALF;
    endfunction

    function automatic int exp_clear_after_release();
        return CLR + 1;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_until_release(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (init_drive_low && n < 1000);
    endtask

    task automatic check_cclk(input logic [2:0] m);
        int exp = exp_cclk_rise(m);
        int k;
        if (exp < 0) begin
            for (int i = 0; i < DLY + HALF + 4; i++) begin
                tick();
                check(cfg_clk_out == 1'b0, "R9 slave clock idle", cfg_clk_out, 0);
            end
        end else begin
            k = 0;
            do begin tick(); k++; end while (!cfg_clk_out && k < 100);
            check(k == exp, "R8 first clock rise", k, exp);
            k = 0;
            do begin tick(); k++; end while (cfg_clk_out && k < 100);
            check(k == HALF, "R8 half period", k, HALF);
        end
        check(mode_q == m, "R7 mode held in load", mode_q, m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n, s, h, len;
        logic [2:0] m;
        void'($urandom(32'd20240611));

        // R1: reset state
        mode_pins = 3'b010;
        repeat (3) tick();
        check(init_drive_low == 1'b1, "R1 drive in reset", init_drive_low, 1);
        check(load_active == 1'b0, "R1 load in reset", load_active, 0);
        check(cfg_clk_out == 1'b0, "R1 clock in reset", cfg_clk_out, 0);
        check(mode_q == 3'b000, "R1 mode in reset", mode_q, 0);

        // R2: power-on plus clear duration
        rst_n = 1'b1;
        count_until_release(n);
        check(n == POR + CLR, "R2 power-on and clear length", n, POR + CLR);
        tick();
        check(load_active == 1'b1, "R6 load entry", load_active, 1);
        check(mode_q == 3'b010, "R7 mode capture", mode_q, 2);
        mode_pins = 3'b101;
        check_cclk(3'b010);

        // Random reprogram cycles
        for (int it = 0; it < 24; it++) begin
            // R4: short pulse ignored
            s = 1 + int'($urandom % (PMIN - 1));
            prog_n = 1'b0;
            repeat (s) tick();
            prog_n = 1'b1;
            tick();
            check(load_active == 1'b1, "R4 short pulse load kept", load_active, 1);
            check(init_drive_low == 1'b0, "R4 short pulse no drive", init_drive_low, 0);

            m   = 3'($urandom % 8);
            h   = int'($urandom % 6);
            len = PMIN + int'($urandom % 4);
            mode_pins = m;
            ext_hold  = (h != 0);

            // R3: accepted request
            prog_n = 1'b0;
            for (int i = 1; i <= len; i++) begin
                tick();
                check(init_drive_low == (i >= PMIN), "R3 drive on accepted request",
                      init_drive_low, (i >= PMIN) ? 1 : 0);
                if (i >= PMIN)
                    check(cfg_clk_out == 1'b0, "R10 clock off outside load", cfg_clk_out, 0);
            end

            // R5: clear length after release
            prog_n = 1'b1;
            count_until_release(n);
            check(n == exp_clear_after_release(), "R5 clear length", n, exp_clear_after_release());

            // R6: stall while held externally
            for (int j = 0; j < h; j++) begin
                tick();
                check(load_active == 1'b0, "R6 stall under hold", load_active, 0);
                check(cfg_clk_out == 1'b0, "R10 clock off during stall", cfg_clk_out, 0);
            end
            ext_hold = 1'b0;
            tick();
            check(load_active == 1'b1, "R6 load after line high", load_active, 1);
            check(mode_q == m, "R7 mode capture", mode_q, m);
            mode_pins = ~m;
            check_cclk(m);
        end

        // R3: request honoured during the power-on wait
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        prog_n = 1'b0;
        repeat (PMIN + 2) tick();
        prog_n = 1'b1;
        count_until_release(n);
        check(n == exp_clear_after_release(), "R3 request during power-on wait", n,
              exp_clear_after_release());

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule